// File: doc/BRIEF.md
# Segment Display Command Decoder and RAM Loader

This block sits behind the address stage of a two-wire serial bus slave in a segment display driver. It takes the bytes that follow a matched slave address and sorts them into command bytes and display data. Command bytes update the display configuration registers: multiplex mode, bias, display enable, blink settings and RAM bank choice. Data bytes are unpacked into a display memory of `NUM_WORDS` 4-bit words, with one word per segment output and one bit per backplane row. The way a byte is split across words depends on the multiplex mode.

Bytes arrive on a valid/ready stream. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls for as long as an accepted data byte is still being written out, at one RAM word per cycle. A sender that holds `in_valid` simply waits. Command bytes never lower `in_ready`. `in_data` has to stay stable while `in_valid` is high and `in_ready` is low.

The write pointer steps forward after each word. When it passes the last word it wraps to 0 and an internal subaddress counter steps by one. This lets several cascaded drivers share one long data stream. A word reaches the RAM port only while that counter equals the hardware subaddress inputs.

Top module: `seg_loader_top`

## Requirements
- R1: After reset the block has `in_ready`=1, `ack_ok`=0, `ram_we`=0, `mux_mode`=3, `disp_en`=0, `bias_third`=0, blink outputs 0, bank outputs 0, write pointer 0 and subaddress counter 0.
- R2: Bit 7 of a command byte is a continuation flag. When it is 1 the next byte is also a command. When it is 0, every later byte in the transfer is display data.
- R3: A `xfer_start` pulse opens a transfer in which the first byte is a command. After a `xfer_stop` pulse, and before any start, accepted bytes change no register and cause no RAM write.
- R4: Mode-set is a byte with bits[6:5]=10. It loads `disp_en` from bit 3, `bias_third` from bit 2 and `mux_mode` from bits[1:0]. The mode codes are 0=static, 1=two rows, 2=three rows and 3=four rows.
- R5: Pointer-load is a byte with bit 6=0. It loads the write pointer from bits[5:0], and a value of `NUM_WORDS` or more loads 0.
- R6: Device-select is a byte with bits[6:3]=1100. It loads the subaddress counter from bits[2:0]. A RAM write happens only while that counter equals `hw_subaddr`, and the pointer still advances while the two differ.
- R7: Blink-select is a byte with bits[6:3]=1101. It loads `blink_alt` from bit 2 and `blink_rate` from bits[1:0]. Bank-select is a byte with bits[6:2]=11100. It loads `bank_in` from bit 1 and `bank_out` from bit 0. Any other byte with bits[6:5]=11 changes nothing.
- R8: In static mode a data byte fills 8 successive words, one bit per word, most significant bit first. The bit goes into row 0, or into row 2 when `bank_in`=1.
- R9: In two-row mode a data byte fills 4 successive words. Each word takes two bits, the earlier bit into row 0 and the later into row 1. With `bank_in`=1 the rows are 2 and 3 instead.
- R10: In three-row mode a data byte fills 3 successive words. Bits 7..5 go to rows 0..2 of the first word and bits 4..2 to rows 0..2 of the second. Bits 1..0 go to rows 0..1 of the third word, and row 2 of that word is left unchanged. `bank_in` has no effect.
- R11: In four-row mode a data byte fills 2 successive words. Bits 7..4 go to rows 0..3 of the first word and bits 3..0 to rows 0..3 of the second.
- R12: After the pointer writes word `NUM_WORDS`-1 it wraps to 0 and the subaddress counter increments.
- R13: The first word of an accepted data byte is on the RAM port in the cycle right after acceptance, one word per cycle follows, and `in_ready` stays low until the last word has been presented.
- R14: `ack_ok` is high from the cycle after a start to the cycle after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Byte stream data |
| xfer_start | input | 1 | One-cycle pulse at a bus start condition |
| xfer_stop | input | 1 | One-cycle pulse at a bus stop condition |
| hw_subaddr | input | 3 | Hardware subaddress straps |
| ack_ok | output | 1 | Transfer open, bytes may be acknowledged |
| ram_we | output | 1 | Display RAM write strobe |
| ram_addr | output | 6 | Display RAM word address |
| ram_wmask | output | 4 | Per-row write mask |
| ram_wdata | output | 4 | Per-row write data |
| mux_mode | output | 2 | Multiplex mode code |
| bias_third | output | 1 | Bias select |
| disp_en | output | 1 | Display enable |
| blink_rate | output | 2 | Blink frequency code |
| blink_alt | output | 1 | Alternate-bank blinking |
| bank_in | output | 1 | Input bank for static and two-row modes |
| bank_out | output | 1 | Output bank select |

## Verification
A command byte accepted on an edge shows its register value one cycle later. The bench therefore reads the registers only after the handshake task has moved on to a later falling edge. A data byte puts its first word on the RAM port in the cycle right after acceptance and then one word per cycle. The bench records every write at falling edges, so each word is seen exactly once. It checks the first word at the first falling edge after acceptance and counts the write cycles until `in_ready` returns. Memory contents and register values are compared with a bench model only after `in_ready` is high again.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  localparam int ROWS   = 4;
  localparam int BYTE_W = 8;
  localparam int SUB_W  = 3;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    K_MODE, K_PTR, K_DEV, K_BLINK, K_BANK, K_NONE
  } cmd_kind_e;

  typedef struct packed {
    logic       disp_en;
    logic       bias_third;
    logic [1:0] mux;
    logic       blink_alt;
    logic [1:0] blink_rate;
    logic       bank_in;
    logic       bank_out;
  } cfg_t;
endpackage

// File: rtl/seg_cmd_decode.sv
module seg_cmd_decode
  import seg_loader_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output cmd_kind_e         kind_o,
  output logic              cont_o
);
  always_comb begin
    cont_o = byte_i[7];
    if (!byte_i[6])                   kind_o = K_PTR;
    else if (!byte_i[5])              kind_o = K_MODE;
    else if (byte_i[4:3] == 2'b00)    kind_o = K_DEV;
    else if (byte_i[4:3] == 2'b01)    kind_o = K_BLINK;
    else if (byte_i[4:2] == 3'b100)   kind_o = K_BANK;
    else                              kind_o = K_NONE;
  end
endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_loader_pkg::*;
#(
  parameter int NUM_WORDS = 40,
  localparam int PTR_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              open_o,
  output cfg_t              cfg_o,
  output logic              data_load_o,
  output logic              ptr_load_o,
  output logic [PTR_W-1:0]  ptr_val_o,
  output logic              sub_load_o,
  output logic [SUB_W-1:0]  sub_val_o
);
  cmd_kind_e kind;
  logic      cont;
  logic      cmd_phase;
  logic      is_cmd;
  logic [5:0] ptr_field;

  seg_cmd_decode u_dec (.byte_i(byte_i), .kind_o(kind), .cont_o(cont));

  assign is_cmd      = take_i && open_o && cmd_phase && !start_i;
  assign data_load_o = take_i && open_o && !cmd_phase && !start_i;
  assign ptr_field   = byte_i[5:0];

  always_comb begin
    ptr_load_o = is_cmd && (kind == K_PTR);
    sub_load_o = is_cmd && (kind == K_DEV);
    sub_val_o  = byte_i[SUB_W-1:0];
    if (int'(ptr_field) >= NUM_WORDS) ptr_val_o = '0;
    else                              ptr_val_o = PTR_W'(ptr_field);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o    <= 1'b0;
      cmd_phase <= 1'b1;
      cfg_o     <= '{disp_en: 1'b0, bias_third: 1'b0, mux: 2'd3,
                     blink_alt: 1'b0, blink_rate: 2'd0,
                     bank_in: 1'b0, bank_out: 1'b0};
    end else begin
      if (start_i) begin
        open_o    <= 1'b1;
        cmd_phase <= 1'b1;
      end else if (stop_i) begin
        open_o    <= 1'b0;
      end
      if (is_cmd) begin
        cmd_phase <= cont;
        unique case (kind)
          K_MODE: begin
            cfg_o.disp_en    <= byte_i[3];
            cfg_o.bias_third <= byte_i[2];
            cfg_o.mux        <= byte_i[1:0];
          end
          K_BLINK: begin
            cfg_o.blink_alt  <= byte_i[2];
            cfg_o.blink_rate <= byte_i[1:0];
          end
          K_BANK: begin
            cfg_o.bank_in    <= byte_i[1];
            cfg_o.bank_out   <= byte_i[0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/seg_unpack.sv
module seg_unpack
  import seg_loader_pkg::*;
#(
  parameter int NUM_WORDS = 40,
  localparam int PTR_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [1:0]        mux_i,
  input  logic              bank_in_i,
  input  logic [SUB_W-1:0]  hw_sub_i,
  input  logic              ptr_load_i,
  input  logic [PTR_W-1:0]  ptr_val_i,
  input  logic              sub_load_i,
  input  logic [SUB_W-1:0]  sub_val_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [PTR_W-1:0]  addr_o,
  output logic [ROWS-1:0]   mask_o,
  output logic [ROWS-1:0]   wdata_o
);
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  left, take, per_word;
  logic [PTR_W-1:0]  ptr;
  logic [SUB_W-1:0]  sub_cnt;
  int                base;

  always_comb begin
    per_word = CNT_W'(mux_i) + CNT_W'(1);
    take     = (left < per_word) ? left : per_word;
    base     = (bank_in_i && !mux_i[1]) ? 2 : 0;
    mask_o   = '0;
    wdata_o  = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (r >= base && (r - base) < int'(take)) begin
        mask_o[r]  = 1'b1;
        wdata_o[r] = shreg[BYTE_W-1-(r-base)];
      end
    end
  end

  assign addr_o = ptr;
  assign we_o   = busy_o && (sub_cnt == hw_sub_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      shreg   <= '0;
      left    <= '0;
      ptr     <= '0;
      sub_cnt <= '0;
    end else if (busy_o) begin
      shreg <= shreg << take;
      left  <= left - take;
      if (left == take) busy_o <= 1'b0;
      if (int'(ptr) == NUM_WORDS - 1) begin
        ptr     <= '0;
        sub_cnt <= sub_cnt + 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end else begin
      if (load_i) begin
        busy_o <= 1'b1;
        shreg  <= byte_i;
        left   <= CNT_W'(BYTE_W);
      end
      if (ptr_load_i) ptr     <= ptr_val_i;
      if (sub_load_i) sub_cnt <= sub_val_i;
    end
  end
endmodule

// File: rtl/seg_loader_top.sv
module seg_loader_top
  import seg_loader_pkg::*;
#(
  parameter int NUM_WORDS = 40,
  localparam int PTR_W = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             xfer_start,
  input  logic             xfer_stop,
  input  logic [2:0]       hw_subaddr,
  output logic             ack_ok,
  output logic             ram_we,
  output logic [PTR_W-1:0] ram_addr,
  output logic [3:0]       ram_wmask,
  output logic [3:0]       ram_wdata,
  output logic [1:0]       mux_mode,
  output logic             bias_third,
  output logic             disp_en,
  output logic [1:0]       blink_rate,
  output logic             blink_alt,
  output logic             bank_in,
  output logic             bank_out
);
  cfg_t             cfg;
  logic             busy, take, data_load, ptr_load, sub_load;
  logic [PTR_W-1:0] ptr_val;
  logic [SUB_W-1:0] sub_val;

  assign in_ready = !busy;
  assign take     = in_valid && in_ready;

  seg_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .take_i(take), .byte_i(in_data),
    .start_i(xfer_start), .stop_i(xfer_stop), .open_o(ack_ok),
    .cfg_o(cfg), .data_load_o(data_load), .ptr_load_o(ptr_load),
    .ptr_val_o(ptr_val), .sub_load_o(sub_load), .sub_val_o(sub_val)
  );

  seg_unpack #(.NUM_WORDS(NUM_WORDS)) u_unpack (
    .clk(clk), .rst_n(rst_n), .load_i(data_load), .byte_i(in_data),
    .mux_i(cfg.mux), .bank_in_i(cfg.bank_in), .hw_sub_i(hw_subaddr),
    .ptr_load_i(ptr_load), .ptr_val_i(ptr_val), .sub_load_i(sub_load),
    .sub_val_i(sub_val), .busy_o(busy), .we_o(ram_we), .addr_o(ram_addr),
    .mask_o(ram_wmask), .wdata_o(ram_wdata)
  );

  assign mux_mode   = cfg.mux;
  assign bias_third = cfg.bias_third;
  assign disp_en    = cfg.disp_en;
  assign blink_rate = cfg.blink_rate;
  assign blink_alt  = cfg.blink_alt;
  assign bank_in    = cfg.bank_in;
  assign bank_out   = cfg.bank_out;
endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk #(
  parameter int NUM_WORDS = 40,
  localparam int PTR_W = $clog2(NUM_WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             xfer_start,
  input logic             xfer_stop,
  input logic             ack_ok,
  input logic             ram_we,
  input logic [PTR_W-1:0] ram_addr,
  input logic [3:0]       ram_wmask,
  input logic [1:0]       mux_mode
);
  // R13
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !in_ready);
  // R14
  open_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> ack_ok);
  // R14
  closed_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stop && !xfer_start) |=> !ack_ok);
  // R12
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (int'(ram_addr) < NUM_WORDS));
  // R8
  static_one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && mux_mode == 2'd0) |-> $countones(ram_wmask) == 1);
  // R11
  quad_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && mux_mode == 2'd3) |-> ram_wmask == 4'hF);
  // R13
  mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready)) |-> $stable(mux_mode));
endmodule

bind seg_loader_top seg_loader_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .xfer_start(xfer_start),
  .xfer_stop(xfer_stop), .ack_ok(ack_ok), .ram_we(ram_we),
  .ram_addr(ram_addr), .ram_wmask(ram_wmask), .mux_mode(mux_mode)
);

// File: tb/seg_loader_top_bench.sv
module seg_loader_top_bench;
  localparam int NW = 40;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, xfer_start = 0, xfer_stop = 0;
  logic [7:0] in_data = 0;
  logic [2:0] hw_subaddr = 0;
  logic in_ready, ack_ok, ram_we, bias_third, disp_en, blink_alt, bank_in, bank_out;
  logic [5:0] ram_addr;
  logic [3:0] ram_wmask, ram_wdata;
  logic [1:0] mux_mode, blink_rate;

  seg_loader_top #(.NUM_WORDS(NW)) u_seg_loader_top (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [3:0] dut_mem [NW];
  logic [3:0] m_mem [NW];
  int m_ptr, m_sub, m_mux, m_en, m_bias, m_alt, m_rate, m_bin, m_bout;
  bit m_open, m_cmd;

  always @(negedge clk)
    if (ram_we) dut_mem[ram_addr] = (dut_mem[ram_addr] & ~ram_wmask) | (ram_wdata & ram_wmask);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] b);
    if (!m_open) return;
    if (m_cmd) begin
      m_cmd = b[7];
      if (!b[6]) m_ptr = (b[5:0] >= NW) ? 0 : int'(b[5:0]);
      else if (!b[5]) begin m_en = b[3]; m_bias = b[2]; m_mux = b[1:0]; end
      else if (b[4:3] == 2'b00) m_sub = b[2:0];
      else if (b[4:3] == 2'b01) begin m_alt = b[2]; m_rate = b[1:0]; end
      else if (b[4:2] == 3'b100) begin m_bin = b[1]; m_bout = b[0]; end
    end else begin
      int bit_i = 7;
      int base = (m_bin == 1 && m_mux < 2) ? 2 : 0;
      while (bit_i >= 0) begin
        for (int r = 0; r <= m_mux && bit_i >= 0; r++) begin
          if (m_sub == int'(hw_subaddr)) m_mem[m_ptr][base + r] = b[bit_i];
          bit_i--;
        end
        if (m_ptr == NW - 1) begin m_ptr = 0; m_sub = (m_sub + 1) % 8; end
        else m_ptr++;
      end
    end
  endtask

  task automatic send(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
    model(b);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic start_x();
    xfer_start = 1; @(negedge clk); xfer_start = 0; @(negedge clk);
    m_open = 1; m_cmd = 1;
  endtask

  task automatic stop_x();
    xfer_stop = 1; @(negedge clk); xfer_stop = 0; @(negedge clk);
    m_open = 0;
  endtask

  task automatic cmp_all(input string req);
    int bad = 0;
    for (int i = 0; i < NW; i++) if (dut_mem[i] !== m_mem[i]) bad++;
    chk(bad == 0, req, bad, 0);
    chk({mux_mode, disp_en, bias_third, blink_alt, blink_rate, bank_in, bank_out} ==
        {2'(m_mux), 1'(m_en), 1'(m_bias), 1'(m_alt), 2'(m_rate), 1'(m_bin), 1'(m_bout)},
        "R4/R7 regs", int'(mux_mode), m_mux);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int wcnt, r;
    for (int i = 0; i < NW; i++) begin dut_mem[i] = 0; m_mem[i] = 0; end
    m_ptr = 0; m_sub = 0; m_mux = 3; m_en = 0; m_bias = 0; m_alt = 0; m_rate = 0;
    m_bin = 0; m_bout = 0; m_open = 0; m_cmd = 1;
    r = $urandom(32'd77);
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset state
    chk(in_ready && !ack_ok && !ram_we, "R1 handshake", int'(in_ready), 1);
    chk(mux_mode == 3 && !disp_en && !bias_third && blink_rate == 0 && !blink_alt
        && !bank_in && !bank_out, "R1 regs", int'(mux_mode), 3);
    // R3 ignored before start
    send(8'h48);
    chk(mux_mode == 3 && !disp_en, "R3 no start", int'(mux_mode), 3);
    start_x();
    chk(ack_ok, "R14 open", int'(ack_ok), 1);
    // R2 R4 chained commands, then R13 static data timing
    send(8'hC8);
    chk(mux_mode == 0 && disp_en, "R4 mode-set", int'(mux_mode), 0);
    send(8'hED);
    chk(blink_alt && blink_rate == 1, "R7 blink", int'(blink_rate), 1);
    send(8'h05);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = 8'hA5; @(negedge clk); in_valid = 0;
    model(8'hA5);
    chk(ram_we && ram_addr == 5 && !in_ready, "R13 first word", int'(ram_addr), 5);
    wcnt = 0;
    while (!in_ready) begin if (ram_we) wcnt++; @(negedge clk); end
    chk(wcnt == 8, "R13 word count", wcnt, 8);
    cmp_all("R8 static");
    // R2: after data phase, a mode-like byte is data
    send(8'hCB);
    chk(mux_mode == 0, "R2 data phase", int'(mux_mode), 0);
    cmp_all("R2 data");
    stop_x();
    chk(!ack_ok, "R14 closed", int'(ack_ok), 0);
    // R3 after stop
    send(8'hFF);
    chk(!ram_we && mux_mode == 0, "R3 after stop", int'(mux_mode), 0);
    cmp_all("R3 mem");
    // R9 bank_in in two-row mode
    start_x(); send(8'hC9); send(8'hF2); send(8'h0A); send(8'h96);
    cmp_all("R9 bank rows");
    stop_x();
    // R10 three-row
    start_x(); send(8'hCA); send(8'h14); send(8'hFF); send(8'h00);
    cmp_all("R10 three-row");
    stop_x();
    // R5 pointer out of range
    start_x(); send(8'hCB); send(8'h3F); send(8'h5A);
    cmp_all("R5 ptr clamp");
    chk(dut_mem[0] == 4'b1010 && dut_mem[1] == 4'b0101, "R11 order",
        int'(dut_mem[0]), 10);
    stop_x();
    // R12 R6 wrap into next subaddress, not written
    start_x(); send(8'hE0); send(8'h27); send(8'hC3); send(8'h77);
    cmp_all("R12 wrap");
    chk(dut_mem[39] == 4'b0011 && dut_mem[0] == 4'b1010, "R6 gated", int'(dut_mem[0]), 10);
    stop_x();
    hw_subaddr = 1;
    start_x(); send(8'h02); send(8'h99);
    cmp_all("R6 sub match");
    stop_x();
    // random transfers
    for (int t = 0; t < 40; t++) begin
      hw_subaddr = 3'($urandom_range(0, 1));
      start_x();
      send(8'hC0 | 8'($urandom_range(0, 15)));
      send(8'hE0 | 8'($urandom_range(0, 1)));
      send(8'hF0 | 8'($urandom_range(0, 3)));
      send(8'($urandom_range(0, 45)));
      for (int k = 0, n = $urandom_range(1, 12); k < n; k++) send(8'($urandom));
      cmp_all("R8-R12 random");
      stop_x();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule